// File: doc/BRIEF.md
# Microcode task-switch address selector

This block sits beside the microsequencer and decides, once per microinstruction, where the next microinstruction address comes from. It keeps one saved program counter for each task. When the control logic announces a task switch, the next address is read from the saved counter of the incoming task. When there is no switch, the address comes from the normal next-address path. The one exception is a plain entry into the kernel, where the address comes from the breakpoint instruction's jump field, or is forced to zero when an error is flagged.

The decision depends on the current and next 3-bit task numbers, on whether the machine is in its second cycle, and on a wait input. Task 0 is the emulator, task 7 is the kernel, and task 6 is a stand-in task used while microcode is being loaded. All other task numbers are I/O tasks. While wait is high the saved counters are frozen, so a task that was held up resumes from where it was. A wait outside cycle 2 pins the kernel or the loader to its saved counter.

The selected address and the switch flag are registered. They appear on the outputs one clock after the inputs that produced them. The switch flag is driven in both polarities.

Top module: `tsw_addr_sel`

## Requirements
- R1: After a synchronous reset, the switch output is 0, the inverted switch output is 1, the address output is 0, and every saved task counter holds 0.
- R2: When cycle-2 is low and wait is low, the switch output one clock later is 0.
- R3: When cycle-2 is high and wait is low, the switch output one clock later is 1. The exceptions are a next task of 7, or current and next tasks both 0; in those cases it is 0.
- R4: When cycle-2 is high and wait is high, the switch output one clock later is 1 for every pair of tasks.
- R5: When cycle-2 is low and wait is high, the switch output one clock later is 1 only if the current task is 6 or 7.
- R6: When a switch is decided, the address output one clock later is the saved counter of the next task.
- R7: When cycle-2 is high, wait is low, the next task is 7 and the current task is not 7, the address output one clock later is the zero-extended jump field. If the error input is high, it is 0 instead.
- R8: When there is no switch and no kernel entry, the address output one clock later equals the normal next address.
- R9: The inverted switch output is always the complement of the switch output.
- R10: At each clock edge where cycle-2 is high and wait is low, the current task's saved counter takes the normal next address.
- R11: While wait is high no saved counter changes. An emulator stopped by wait and selected again resumes from its old counter.
- R12: If a switch reads the counter being written at that same edge (current task equal to next task), the address output is the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_task_i | input | TASK_W | Task executing now |
| nxt_task_i | input | TASK_W | Task chosen to run next |
| cyc2_i | input | 1 | Second-cycle phase flag |
| wait_i | input | 1 | Hold request |
| seq_addr_i | input | ADDR_W | Normal next address |
| goto_i | input | GOTO_W | Jump field of the breakpoint instruction |
| kerr_i | input | 1 | Error flag forcing kernel entry to address 0 |
| addr_o | output | ADDR_W | Registered selected next address |
| sw_o | output | 1 | Registered switch flag, active high |
| sw_n_o | output | 1 | Registered switch flag, active low |

## Verification
The bench sweeps all 64 task pairs in cycle 2 without wait. This exposes a design that switches into the kernel or between two emulator cycles, or that misses an I/O-to-I/O switch. Wait is applied both inside and outside cycle 2. A design that writes counters during wait, or that releases the kernel and the loader, then returns a stale or moved address. Kernel entry is tried with the error flag low and high, to catch a wrong jump-field extension or a missing zero override. A same-task switch checks that the counter being written is forwarded, since a design without that forwarding would return the previous value.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  // combined decision for one cycle
  typedef struct packed {
    logic sw;      // take the next task's saved counter
    logic kentry;  // plain entry into the kernel
    logic tpc_we;  // save the current task's next address
  } tsw_dec_t;
endpackage

// File: rtl/tsw_decide.sv
module tsw_decide
  import tsw_pkg::*;
#(
  parameter int TASK_W    = 3,
  parameter int EMU_ID    = 0,
  parameter int LOADER_ID = 6,
  parameter int KERN_ID   = 7
) (
  input  logic [TASK_W-1:0] cur_task_i,
  input  logic [TASK_W-1:0] nxt_task_i,
  input  logic              cyc2_i,
  input  logic              wait_i,
  output tsw_dec_t          dec_o
);
  localparam logic [TASK_W-1:0] EMU_T    = TASK_W'(EMU_ID);
  localparam logic [TASK_W-1:0] LOADER_T = TASK_W'(LOADER_ID);
  localparam logic [TASK_W-1:0] KERN_T   = TASK_W'(KERN_ID);

  logic nxt_kern, cur_kern, emu_stay, cur_pinned;

  always_comb begin
    nxt_kern   = (nxt_task_i == KERN_T);
    cur_kern   = (cur_task_i == KERN_T);
    emu_stay   = (cur_task_i == EMU_T) && (nxt_task_i == EMU_T);
    cur_pinned = cur_kern || (cur_task_i == LOADER_T);

    if (cyc2_i) begin
      dec_o.sw = wait_i || (!nxt_kern && !emu_stay);
    end else begin
      dec_o.sw = wait_i && cur_pinned;
    end
    dec_o.kentry = cyc2_i && !wait_i && nxt_kern && !cur_kern;
    dec_o.tpc_we = cyc2_i && !wait_i;
  end
endmodule

// File: rtl/tsw_tpc_file.sv
module tsw_tpc_file #(
  parameter int TASK_W = 3,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [TASK_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [TASK_W-1:0] raddr_i,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int NTASK = 1 << TASK_W;

  logic [ADDR_W-1:0] mem [NTASK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTASK; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // forward a same-edge write so a self-switch sees the fresh value
  always_comb begin
    if (we_i && (waddr_i == raddr_i)) rdata_o = wdata_i;
    else                              rdata_o = mem[raddr_i];
  end
endmodule

// File: rtl/tsw_addr_mux.sv
module tsw_addr_mux
  import tsw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int GOTO_W = 8
) (
  input  tsw_dec_t          dec_i,
  input  logic              kerr_i,
  input  logic [GOTO_W-1:0] goto_i,
  input  logic [ADDR_W-1:0] tpc_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] entry;

  always_comb begin
    entry = kerr_i ? '0 : ADDR_W'(goto_i);
    if (dec_i.sw)          addr_o = tpc_i;
    else if (dec_i.kentry) addr_o = entry;
    else                   addr_o = seq_addr_i;
  end
endmodule

// File: rtl/tsw_addr_sel.sv
module tsw_addr_sel
  import tsw_pkg::*;
#(
  parameter int TASK_W    = 3,
  parameter int ADDR_W    = 12,
  parameter int GOTO_W    = 8,
  parameter int EMU_ID    = 0,
  parameter int LOADER_ID = 6,
  parameter int KERN_ID   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TASK_W-1:0] cur_task_i,
  input  logic [TASK_W-1:0] nxt_task_i,
  input  logic              cyc2_i,
  input  logic              wait_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  input  logic [GOTO_W-1:0] goto_i,
  input  logic              kerr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sw_o,
  output logic              sw_n_o
);
  tsw_dec_t          dec;
  logic [ADDR_W-1:0] tpc_rd;
  logic [ADDR_W-1:0] addr_nx;

  tsw_decide #(
    .TASK_W(TASK_W), .EMU_ID(EMU_ID), .LOADER_ID(LOADER_ID), .KERN_ID(KERN_ID)
  ) u_decide (
    .cur_task_i(cur_task_i),
    .nxt_task_i(nxt_task_i),
    .cyc2_i    (cyc2_i),
    .wait_i    (wait_i),
    .dec_o     (dec)
  );

  tsw_tpc_file #(.TASK_W(TASK_W), .ADDR_W(ADDR_W)) u_tpc (
    .clk    (clk),
    .rst    (rst),
    .we_i   (dec.tpc_we),
    .waddr_i(cur_task_i),
    .wdata_i(seq_addr_i),
    .raddr_i(nxt_task_i),
    .rdata_o(tpc_rd)
  );

  tsw_addr_mux #(.ADDR_W(ADDR_W), .GOTO_W(GOTO_W)) u_mux (
    .dec_i     (dec),
    .kerr_i    (kerr_i),
    .goto_i    (goto_i),
    .tpc_i     (tpc_rd),
    .seq_addr_i(seq_addr_i),
    .addr_o    (addr_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      sw_o   <= 1'b0;
      sw_n_o <= 1'b1;
    end else begin
      addr_o <= addr_nx;
      sw_o   <= dec.sw;
      sw_n_o <= ~dec.sw;
    end
  end
endmodule

// File: rtl/tsw_addr_sel_chk.sv
module tsw_addr_sel_chk #(
  parameter int TASK_W    = 3,
  parameter int ADDR_W    = 12,
  parameter int GOTO_W    = 8,
  parameter int EMU_ID    = 0,
  parameter int LOADER_ID = 6,
  parameter int KERN_ID   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [TASK_W-1:0] cur_task_i,
  input logic [TASK_W-1:0] nxt_task_i,
  input logic              cyc2_i,
  input logic              wait_i,
  input logic [ADDR_W-1:0] seq_addr_i,
  input logic [GOTO_W-1:0] goto_i,
  input logic              kerr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              sw_o,
  input logic              sw_n_o
);
  localparam logic [TASK_W-1:0] EMU_T    = TASK_W'(EMU_ID);
  localparam logic [TASK_W-1:0] LOADER_T = TASK_W'(LOADER_ID);
  localparam logic [TASK_W-1:0] KERN_T   = TASK_W'(KERN_ID);

  p_compl_r9: assert property (@(posedge clk) disable iff (rst)
    sw_o == !sw_n_o);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!cyc2_i && !wait_i) |=> !sw_o);

  p_kern_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc2_i && !wait_i && nxt_task_i == KERN_T) |=> !sw_o);

  p_emu_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc2_i && !wait_i && cur_task_i == EMU_T && nxt_task_i == EMU_T) |=> !sw_o);

  p_waitc2_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc2_i && wait_i) |=> sw_o);

  p_waitfree_r5: assert property (@(posedge clk) disable iff (rst)
    (!cyc2_i && wait_i && cur_task_i != KERN_T && cur_task_i != LOADER_T) |=> !sw_o);

  p_waitpin_r5: assert property (@(posedge clk) disable iff (rst)
    (!cyc2_i && wait_i && (cur_task_i == KERN_T || cur_task_i == LOADER_T)) |=> sw_o);

  p_kerr_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc2_i && !wait_i && nxt_task_i == KERN_T && cur_task_i != KERN_T && kerr_i)
    |=> addr_o == '0);

  p_goto_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc2_i && !wait_i && nxt_task_i == KERN_T && cur_task_i != KERN_T && !kerr_i)
    |=> addr_o == ADDR_W'($past(goto_i)));

  p_seq_r8: assert property (@(posedge clk) disable iff (rst)
    (!cyc2_i && !wait_i) |=> addr_o == $past(seq_addr_i));
endmodule

bind tsw_addr_sel tsw_addr_sel_chk #(
  .TASK_W(TASK_W), .ADDR_W(ADDR_W), .GOTO_W(GOTO_W),
  .EMU_ID(EMU_ID), .LOADER_ID(LOADER_ID), .KERN_ID(KERN_ID)
) i_chk (
  .clk(clk), .rst(rst), .cur_task_i(cur_task_i), .nxt_task_i(nxt_task_i),
  .cyc2_i(cyc2_i), .wait_i(wait_i), .seq_addr_i(seq_addr_i), .goto_i(goto_i),
  .kerr_i(kerr_i), .addr_o(addr_o), .sw_o(sw_o), .sw_n_o(sw_n_o)
);

// File: tb/test_tsw_addr_sel.sv
`timescale 1ns/1ps
module test_tsw_addr_sel;
  localparam int TW = 3;
  localparam int AW = 12;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] ct = '0, nt = '0;
  logic          c2 = 1'b0, wt = 1'b0, err = 1'b0;
  logic [AW-1:0] seq = '0;
  logic [GW-1:0] gf = '0;
  logic [AW-1:0] addr;
  logic          sw, swn;

  int vectors = 0;
  int misses  = 0;
  logic [AW-1:0] model [8];

  always #5 clk = ~clk;

  tsw_addr_sel i_tsw_addr_sel (
    .clk(clk), .rst(rst), .cur_task_i(ct), .nxt_task_i(nt), .cyc2_i(c2),
    .wait_i(wt), .seq_addr_i(seq), .goto_i(gf), .kerr_i(err),
    .addr_o(addr), .sw_o(sw), .sw_n_o(swn)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle at a negedge, predict from the requirements, compare at the next negedge
  task automatic step(int c, int n, bit cy, bit w, int s, int g, bit e, string req);
    bit          esw;
    logic [AW-1:0] eaddr;
    ct = TW'(c); nt = TW'(n); c2 = cy; wt = w; seq = AW'(s); gf = GW'(g); err = e;
    if (cy) esw = w || (n != 7 && !(c == 0 && n == 0));
    else    esw = w && (c == 6 || c == 7);
    if (esw) eaddr = (cy && !w && c == n) ? AW'(s) : model[n];
    else if (cy && !w && n == 7 && c != 7) eaddr = e ? '0 : AW'(g);
    else eaddr = AW'(s);
    if (cy && !w) model[c] = AW'(s);
    @(negedge clk);
    check({req, " sw"}, 32'(sw), 32'(esw));
    check("R9 complement", 32'(swn), 32'(!esw));
    check({req, " addr"}, 32'(addr), 32'(eaddr));
  endtask

  task automatic t_reset;
    check("R1 sw", 32'(sw), 0);
    check("R1 sw_n", 32'(swn), 1);
    check("R1 addr", 32'(addr), 0);
    step(1, 5, 1, 1, 'h3AA, 0, 0, "R1 R4 R6 zeroed counter");
  endtask

  task automatic t_idle;
    for (int c = 0; c < 8; c++) step(c, (c + 3) % 8, 0, 0, 'h050 + c, 'hFF, 0, "R2 R8");
  endtask

  task automatic t_truth;
    for (int c = 0; c < 8; c++)
      for (int n = 0; n < 8; n++)
        step(c, n, 1, 0, 'h100 + c * 8 + n, 'h33, 0, "R3 R10");
  endtask

  task automatic t_kentry;
    step(2, 7, 1, 0, 'h777, 'h5A, 0, "R7 goto");
    step(0, 7, 1, 0, 'h666, 'hC3, 1, "R7 error zero");
    step(7, 7, 1, 0, 'h123, 'h11, 0, "R8 kernel stays");
  endtask

  task automatic t_wait_c2;
    for (int n = 0; n < 8; n++) step(n ^ 5, n, 1, 1, 'hEEE, 'h22, 0, "R4 R6");
  endtask

  task automatic t_wait_free;
    for (int c = 0; c < 8; c++) step(c, 7, 0, 1, 'h0D0 + c, 'h44, 0, "R5");
    step(6, 6, 0, 1, 'h0F0, 0, 0, "R5 loader pinned");
  endtask

  task automatic t_nowrite;
    step(0, 3, 1, 0, 'h321, 0, 0, "R10 emu save");
    step(0, 0, 1, 1, 'h777, 0, 0, "R11 emu waits");
    step(3, 0, 1, 0, 'h444, 0, 0, "R11 emu resumes");
    check("R11 emu counter", 32'(addr), 32'h321);
  endtask

  task automatic t_bypass;
    step(4, 4, 1, 0, 'hABC, 0, 0, "R12 same task");
    check("R12 forwarded", 32'(addr), 32'hABC);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_truth();
    t_kentry();
    t_wait_c2();
    t_wait_free();
    t_nowrite();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000ns;
    vectors++;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule